// File: doc/BRIEF.md
# Serial EEPROM status and write-protection guard

This block keeps the status byte of a serial EEPROM and decides whether each write request from the serial front end may go ahead. The front end decodes each command and presents it as a one-cycle strobe. The strobes are write-enable, write-disable, status write (with its data byte) and array write (with its target byte address). The guard combines those strobes with three things: the write-enable latch, whether a self-timed cycle is running, and the protection state. From these it raises an accept flag in the same cycle as the strobe.

Protection has two layers. A two-bit block-protect code fences off the top quarter, the top half or the whole array against array writes. A hardware-protected mode locks the status register itself. That mode holds while the status write-disable bit is 1 and the write-protect pin is low.

An accepted write starts a self-timed cycle. The busy bit stays set until the array controller pulses `cycle_done`. New protect settings from a status write take effect only when its cycle completes.

Top module: `eeprom_status_guard`

## Requirements
- R1: The status byte is {write-disable (bit 7), three zero bits (6..4), block-protect code (bits 3..2), write-enable latch (bit 1), busy (bit 0)}. It reads 0x00 after reset.
- R2: A completed status write loads only bit 7 and bits 3..2 from its data byte. Data bits 6, 5, 4, 1 and 0 are ignored, and bits 6..4 stay 0.
- R3: With ADDR_W=11, `prot_lo` and `prot_any` follow the block-protect code. Code 00 protects nothing (`prot_any`=0). Code 01 protects 0x600..0x7FF, code 10 protects 0x400..0x7FF, and code 11 protects 0x000..0x7FF. `prot_hi` is 0x7FF whenever `prot_any` is 1.
- R4: The write-enable strobe sets the latch and the write-disable strobe clears it. While a cycle runs, both strobes have no effect.
- R5: A `cycle_done` pulse while busy clears both the busy bit and the write-enable latch. While idle, `cycle_done` has no effect.
- R6: `wr_ok` is 1 in the strobe cycle only when the latch is set, no cycle runs, and the address lies below `prot_lo` (or nothing is protected).
- R7: `wrsr_ok` is 1 in the strobe cycle only when the latch is set, no cycle runs, and hardware-protected mode is off.
- R8: Hardware-protected mode is write-disable = 1 with `wp_n` = 0. It can be entered in either order, and it is left by driving `wp_n` high.
- R9: During a status-write cycle the previous write-disable and block-protect values stay visible and stay in force. The new values appear in the cycle after `cycle_done`.
- R10: After an accepted array or status write, the busy bit reads 1 from the next cycle until the cycle after `cycle_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status-write command strobe |
| cmd_sr_data | input | 8 | Data byte of the status write |
| cmd_write | input | 1 | Array-write request strobe |
| cmd_addr | input | ADDR_W | Target byte address of the array write |
| wp_n | input | 1 | Write-protect pin, low = protect |
| cycle_done | input | 1 | Pulse ending the self-timed cycle |
| status | output | 8 | Status byte |
| wr_ok | output | 1 | Array write accepted |
| wrsr_ok | output | 1 | Status write accepted |
| prot_any | output | 1 | Some range is protected |
| prot_lo | output | ADDR_W | Lowest protected address |
| prot_hi | output | ADDR_W | Highest protected address |

## Verification
The bench sweeps every block-protect code across the first and last byte of every page. A wrong quarter boundary would show up as a refused or accepted write on exactly one page pair.

It applies the new protect values mid-cycle and looks at the status byte before `cycle_done`. A design that applied the values at acceptance would show them early.

It enters hardware-protected mode in both orders and then leaves it through the pin. It also sends write-enable, write-disable and extra done pulses at the wrong times. A design that let any of these through would leave a wrong latch or busy bit in the status byte.

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        cmd_sr_data,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wp_n,
  input  logic              cycle_done,
  output logic [7:0]        status,
  output logic              wr_ok,
  output logic              wrsr_ok,
  output logic              prot_any,
  output logic [ADDR_W-1:0] prot_lo,
  output logic [ADDR_W-1:0] prot_hi
);
  localparam int QW = ADDR_W - 2;

  logic       srwd, wel, busy, sr_pend, nxt_srwd;
  logic [1:0] bp, nxt_bp;
  logic       hw_lock, in_fence;

  assign hw_lock  = srwd & ~wp_n;
  assign prot_any = |bp;
  assign prot_hi  = prot_any ? {ADDR_W{1'b1}} : '0;

  always_comb begin
    case (bp)
      2'b01:   prot_lo = {2'b11, {QW{1'b0}}};
      2'b10:   prot_lo = {2'b10, {QW{1'b0}}};
      default: prot_lo = '0;
    endcase
  end

  assign in_fence = prot_any & (cmd_addr >= prot_lo);
  assign wr_ok    = cmd_write & wel & ~busy & ~in_fence;
  assign wrsr_ok  = cmd_wrsr & wel & ~busy & ~hw_lock;
  assign status   = {srwd, 3'b000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srwd     <= 1'b0;
      bp       <= 2'b00;
      wel      <= 1'b0;
      busy     <= 1'b0;
      sr_pend  <= 1'b0;
      nxt_srwd <= 1'b0;
      nxt_bp   <= 2'b00;
    end else if (busy) begin
      if (cycle_done) begin
        busy    <= 1'b0;
        wel     <= 1'b0;
        sr_pend <= 1'b0;
        if (sr_pend) begin
          srwd <= nxt_srwd;
          bp   <= nxt_bp;
        end
      end
    end else if (wr_ok || wrsr_ok) begin
      busy     <= 1'b1;
      sr_pend  <= wrsr_ok;
      nxt_srwd <= cmd_sr_data[7];
      nxt_bp   <= cmd_sr_data[3:2];
    end else if (cmd_wren) begin
      wel <= 1'b1;
    end else if (cmd_wrdi) begin
      wel <= 1'b0;
    end
  end

  a_r6_write_needs_latch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> (status[1] && !status[0]));

  a_r8_locked_status_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && status[7] && !wp_n) |-> !wrsr_ok);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok || wrsr_ok) |=> status[0]);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && cycle_done) |=> (!status[1] && !status[0]));

  a_r9_protect_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !cycle_done) |=> $stable(status[7:2]));
endmodule

// File: tb/test_eeprom_status_guard.sv
module test_eeprom_status_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_write = 0, cycle_done = 0;
  logic [7:0]  cmd_sr_data = 8'h00;
  logic [10:0] cmd_addr = '0;
  logic        wp_n = 1'b1;
  logic [7:0]  status;
  logic        wr_ok, wrsr_ok, prot_any;
  logic [10:0] prot_lo, prot_hi;

  int checks = 0, errors = 0, cyc = 0;
  logic acc_w, acc_s;

  eeprom_status_guard #(.ADDR_W(11)) i_eeprom_status_guard (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_wrsr(cmd_wrsr), .cmd_sr_data(cmd_sr_data), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .wp_n(wp_n), .cycle_done(cycle_done), .status(status),
    .wr_ok(wr_ok), .wrsr_ok(wrsr_ok), .prot_any(prot_any), .prot_lo(prot_lo),
    .prot_hi(prot_hi));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic op(input bit wren, input bit wrdi, input bit wrsr, input logic [7:0] d,
                    input bit wr, input logic [10:0] a, input bit done);
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; cmd_sr_data = d;
    cmd_write = wr; cmd_addr = a; cycle_done = done;
    #1;
    acc_w = wr_ok; acc_s = wrsr_ok;
    @(posedge clk); #1;
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; cmd_write = 0; cycle_done = 0;
  endtask

  task automatic wren();            op(1,0,0,8'h00,0,'0,0); endtask
  task automatic wrdi();            op(0,1,0,8'h00,0,'0,0); endtask
  task automatic wrsr(input logic [7:0] d); op(0,0,1,d,0,'0,0); endtask
  task automatic wrarr(input logic [10:0] a); op(0,0,0,8'h00,1,a,0); endtask
  task automatic done();            op(0,0,0,8'h00,0,'0,1); endtask

  task automatic set_sr(input logic [7:0] d);
    wren(); wrsr(d); done();
  endtask

  initial begin
    int lo;
    logic [10:0] a;
    bit exp_acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R3 reset prot_any", prot_any, 0);

    // R4 latch set/clear, R6 write refused without latch
    wren();  chk("R4 wren sets latch", status, 8'h02);
    wrdi();  chk("R4 wrdi clears latch", status, 8'h00);
    wrarr(11'h000); chk("R6 write without latch", acc_w, 0);
    wrsr(8'h8C); chk("R7 status write without latch", acc_s, 0);
    chk("R7 no busy after refusal", status, 8'h00);

    // R2, R9, R10, R5 during a status-write cycle
    wren();
    wrsr(8'hFF); chk("R7 status write accepted", acc_s, 1);
    chk("R9 old values while busy", status, 8'h03);
    chk("R9 old protect in force", prot_any, 0);
    wrdi();  chk("R4 wrdi ignored while busy", status, 8'h03);
    wren();  chk("R4 wren ignored while busy", status, 8'h03);
    wrarr(11'h000); chk("R6 write refused while busy", acc_w, 0);
    wren(); wrsr(8'h00); chk("R7 status write refused while busy", acc_s, 0);
    chk("R10 busy held until done", status[0], 1);
    done();  chk("R2 only bits 7,3,2 loaded", status, 8'h8C);
    done();  chk("R5 done ignored when idle", status, 8'h8C);
    set_sr(8'h73); chk("R2 ignored bits and clear", status, 8'h00);

    // R3 / R6 sweep over every code and page edge
    for (int code = 0; code < 4; code++) begin
      set_sr({4'b0000, code[1:0], 2'b00});
      chk("R1 code in status", status, {4'b0000, code[1:0], 2'b00});
      lo = (code == 1) ? 1536 : (code == 2) ? 1024 : 0;
      chk("R3 prot_any", prot_any, code != 0);
      if (code != 0) begin
        chk("R3 prot_lo", prot_lo, lo);
        chk("R3 prot_hi", prot_hi, 2047);
      end
      for (int p = 0; p < 64; p++) begin
        for (int e = 0; e < 2; e++) begin
          a = 11'(p * 32 + e * 31);
          exp_acc = (code == 0) || (int'(a) < lo);
          wren();
          wrarr(a);
          chk("R3 R6 fence decision", acc_w, exp_acc);
          if (acc_w) begin
            chk("R10 busy after write", status, {4'b0000, code[1:0], 2'b11});
            done();
            chk("R5 done clears latch and busy", status, {4'b0000, code[1:0], 2'b00});
          end else begin
            wrdi();
          end
        end
      end
    end
    set_sr(8'h00);

    // R8 lock: write-disable first, then pin low
    set_sr(8'h80); chk("R2 write-disable set", status, 8'h80);
    @(negedge clk); wp_n = 1'b0;
    wren(); wrsr(8'h00); chk("R8 refused in locked mode", acc_s, 0);
    chk("R8 status unchanged and idle", status, 8'h82);
    @(negedge clk); wp_n = 1'b1;
    wrsr(8'h00); chk("R8 pin high unlocks", acc_s, 1);
    done(); chk("R8 cleared", status, 8'h00);
    // pin low first, then write-disable
    @(negedge clk); wp_n = 1'b0;
    wren(); wrsr(8'h84); chk("R8 accepted with bit 0 and pin low", acc_s, 1);
    done(); chk("R8 bit set", status, 8'h84);
    wren(); wrsr(8'h00); chk("R8 refused second order", acc_s, 0);
    wrarr(11'h000); chk("R6 unprotected write still allowed", acc_w, 1);
    done();
    @(negedge clk); wp_n = 1'b1;
    set_sr(8'h00); chk("R8 left by pin high", status, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule